// File: doc/BRIEF.md
# Serial Port Byte FIFO Pair with Status Registers

This block sits between a processor bus and the shift logic of a serial I/O port. It holds two byte FIFOs of four entries each. Transmit bytes are written over the bus into a shared data buffer address and leave one at a time when the shifter asks for them. Received bytes come in from the shifter and are read back through that same buffer address. Two status registers report each FIFO's fill level and a sticky error flag. The receive side flags overrun and the transmit side flags underrun. Each flag clears as a side effect of the matching buffer access.

A one-bit enable register gates the whole unit. While it is clear, every other address reads as zero and ignores writes, and the shifter strobes are ignored. The FIFO contents and flags are kept, so the port can be paused and resumed without losing state. The bus interface is a simple single-cycle strobe port. Read data is combinational from the selected address, and a read or write takes effect at the next rising clock edge.

Top module: `serFifoStatus`

## Requirements
- R1: After reset the enable bit is 0, both FIFOs are empty, both flags are 0, and every address reads 0x00.
- R2: Address 3 holds the enable bit in bit 0. It is writable at any time, and bits 7:1 always read 0 (writing 0xFF reads back 0x01).
- R3: While the enable bit is 0, reads of addresses 0 to 2 return 0x00 and pop nothing. Writes to them are ignored, and shifter push and pop strobes have no effect.
- R4: Clearing the enable bit keeps the FIFO contents, the levels and the flags. They read back unchanged once the bit is set again.
- R5: Address 1 (receive status) and address 2 (transmit status) carry the FIFO level in bits 2:0 (0 = empty, 1 to 3 = that many bytes, 4 = full), the error flag in bit 7, and 0 in bits 6:3.
- R6: Bytes leave each FIFO in arrival order. A read of address 0 returns the oldest received byte and removes it. The transmit output shows the oldest transmit byte while that FIFO is not empty.
- R7: A bus write to a full transmit FIFO is dropped. A read of address 0 with the receive FIFO empty returns 0x00 and changes nothing.
- R8: A shifter push into a full receive FIFO, with no read in the same cycle, sets the overrun flag and drops the byte.
- R9: An enabled read of address 0 clears the overrun flag.
- R10: A shifter pop from an empty transmit FIFO sets the underrun flag.
- R11: An enabled write to address 0 clears the underrun flag.
- R12: When a flag is set and cleared in the same cycle, it ends up set.
- R13: A push and a pop in the same cycle on a non-empty FIFO leave its level unchanged, and the pushed byte is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 2 | Register address: 0 data buffer, 1 receive status, 2 transmit status, 3 enable |
| busRd | input | 1 | Read strobe for the addressed register |
| busWr | input | 1 | Write strobe for the addressed register |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data of the addressed register, combinational |
| shTxPop | input | 1 | Shifter takes one byte from the transmit FIFO |
| shTxData | output | 8 | Oldest byte of the transmit FIFO |
| shRxPush | input | 1 | Shifter delivers one byte to the receive FIFO |
| shRxData | input | 8 | Byte delivered by the shifter |

## Verification
All state changes land on the rising edge that samples a strobe. Their effect is visible in the same-cycle combinational read data of the following cycle, so a status read placed right after a push, pop or buffer access shows its result with zero extra latency. The bench drives inputs just after the falling edge and compares read data and the transmit output one time unit later, against a queue-based model advanced at each rising edge. Every cycle is therefore checked against the state produced by exactly the preceding edge.

// File: rtl/sfsPkg.sv
package sfsPkg;
  localparam logic [1:0] ADDR_BUF   = 2'd0;
  localparam logic [1:0] ADDR_RXST  = 2'd1;
  localparam logic [1:0] ADDR_TXST  = 2'd2;
  localparam logic [1:0] ADDR_EN    = 2'd3;

  typedef struct packed {
    logic txPush;
    logic txPop;
    logic rxPush;
    logic rxPop;
  } sfsStrobeT;
endpackage

// File: rtl/sfsFifo.sv
module sfsFifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [W-1:0]     din,
  output logic [W-1:0]     dout,
  output logic [LVL_W-1:0] level
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      level <= level + LVL_W'(push) - LVL_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= din;
  end

  assign dout = mem[rdPtr];

  // R7
  full_push_chk: assert property (@(posedge clk) disable iff (!rstN)
    (push && level == LVL_W'(DEPTH)) |-> pop);
  // R6
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> level != '0);
  // R13
  pushpop_lvl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (push && pop) |=> level == $past(level));
  // R5
  lvl_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    level <= LVL_W'(DEPTH));
endmodule

// File: rtl/sfsData.sv
module sfsData import sfsPkg::*; #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  parameter int LVL_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  sfsStrobeT         strobe,
  input  logic [DATA_W-1:0] txIn,
  input  logic [DATA_W-1:0] rxIn,
  output logic [DATA_W-1:0] txHead,
  output logic [DATA_W-1:0] rxHead,
  output logic [LVL_W-1:0]  txLvl,
  output logic [LVL_W-1:0]  rxLvl
);
  sfsFifo #(.W(DATA_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_txFifo (
    .clk(clk), .rstN(rstN), .push(strobe.txPush), .pop(strobe.txPop),
    .din(txIn), .dout(txHead), .level(txLvl));

  sfsFifo #(.W(DATA_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_rxFifo (
    .clk(clk), .rstN(rstN), .push(strobe.rxPush), .pop(strobe.rxPop),
    .din(rxIn), .dout(rxHead), .level(rxLvl));
endmodule

// File: rtl/sfsCtrl.sv
module sfsCtrl import sfsPkg::*; #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  parameter int LVL_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic              wrBit,
  input  logic              shTxPop,
  input  logic              shRxPush,
  input  logic [LVL_W-1:0]  txLvl,
  input  logic [LVL_W-1:0]  rxLvl,
  input  logic [DATA_W-1:0] rxHead,
  output sfsStrobeT         strobe,
  output logic [DATA_W-1:0] busRdata
);
  localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

  logic en, rxOvr, txUdr;
  logic rdBuf, wrBuf, ovrSet, udrSet, rxEmpty, txEmpty;
  logic [DATA_W-1:0] rxStat, txStat;

  assign rxEmpty = (rxLvl == '0);
  assign txEmpty = (txLvl == '0);
  assign rdBuf   = en && busRd && (busAddr == ADDR_BUF);
  assign wrBuf   = en && busWr && (busAddr == ADDR_BUF);

  always_comb begin
    strobe.rxPop  = rdBuf && !rxEmpty;
    strobe.txPop  = en && shTxPop && !txEmpty;
    strobe.rxPush = en && shRxPush && ((rxLvl != FULL) || strobe.rxPop);
    strobe.txPush = wrBuf && ((txLvl != FULL) || strobe.txPop);
    ovrSet        = en && shRxPush && (rxLvl == FULL) && !strobe.rxPop;
    udrSet        = en && shTxPop && txEmpty;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      en    <= 1'b0;
      rxOvr <= 1'b0;
      txUdr <= 1'b0;
    end else begin
      if (busWr && busAddr == ADDR_EN) en <= wrBit;
      if (ovrSet)     rxOvr <= 1'b1;
      else if (rdBuf) rxOvr <= 1'b0;
      if (udrSet)     txUdr <= 1'b1;
      else if (wrBuf) txUdr <= 1'b0;
    end
  end

  always_comb begin
    rxStat = '0;
    rxStat[LVL_W-1:0] = rxLvl;
    rxStat[DATA_W-1]  = rxOvr;
    txStat = '0;
    txStat[LVL_W-1:0] = txLvl;
    txStat[DATA_W-1]  = txUdr;
    busRdata = '0;
    case (busAddr)
      ADDR_BUF:  if (en && !rxEmpty) busRdata = rxHead;
      ADDR_RXST: if (en) busRdata = rxStat;
      ADDR_TXST: if (en) busRdata = txStat;
      default:   busRdata[0] = en;
    endcase
  end

  // R2
  en_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == ADDR_EN) |=> en == $past(wrBit));
  // R3
  off_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> (rxOvr == $past(rxOvr)) && (txUdr == $past(txUdr)));
  // R3
  off_nostrobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !en |-> strobe == '0);
  // R8
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (en && shRxPush && rxLvl == FULL && !busRd) |=> rxOvr);
  // R9
  ovr_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (en && busRd && busAddr == ADDR_BUF && !shRxPush) |=> !rxOvr);
  // R10
  udr_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (en && shTxPop && txEmpty) |=> txUdr);
endmodule

// File: rtl/serFifoStatus.sv
module serFifoStatus import sfsPkg::*; #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              shTxPop,
  output logic [DATA_W-1:0] shTxData,
  input  logic              shRxPush,
  input  logic [DATA_W-1:0] shRxData
);
  localparam int LVL_W = $clog2(DEPTH + 1);

  sfsStrobeT         strobe;
  logic [LVL_W-1:0]  txLvl, rxLvl;
  logic [DATA_W-1:0] rxHead;

  sfsCtrl #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .wrBit(busWdata[0]), .shTxPop(shTxPop), .shRxPush(shRxPush),
    .txLvl(txLvl), .rxLvl(rxLvl), .rxHead(rxHead), .strobe(strobe),
    .busRdata(busRdata));

  sfsData #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txIn(busWdata), .rxIn(shRxData),
    .txHead(shTxData), .rxHead(rxHead), .txLvl(txLvl), .rxLvl(rxLvl));
endmodule

// File: tb/serFifoStatus_tb.sv
module serFifoStatus_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] busAddr = '0;
  logic       busRd = 1'b0, busWr = 1'b0, shTxPop = 1'b0, shRxPush = 1'b0;
  logic [7:0] busWdata = '0, shRxData = '0;
  logic [7:0] busRdata, shTxData;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] rxQ[$];
  logic [7:0] txQ[$];
  bit mEn = 0, mOvr = 0, mUdr = 0;

  serFifoStatus u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .shTxPop(shTxPop),
    .shTxData(shTxData), .shRxPush(shRxPush), .shRxData(shRxData));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] expRead(input logic [1:0] a);
    logic [7:0] v;
    v = 8'h00;
    if (a == 2'd3) v = {7'b0, mEn};
    else if (mEn) begin
      if (a == 2'd0) v = (rxQ.size() > 0) ? rxQ[0] : 8'h00;
      else if (a == 2'd1) v = {mOvr, 4'b0, 3'(rxQ.size())};
      else v = {mUdr, 4'b0, 3'(txQ.size())};
    end
    return v;
  endfunction

  task automatic modelEdge();
    bit rdB, wrB, rxPopM, ovrSetM, txPopM, udrSetM, txDrop;
    if (mEn) begin
      rdB     = busRd && busAddr == 2'd0;
      wrB     = busWr && busAddr == 2'd0;
      rxPopM  = rdB && rxQ.size() > 0;
      ovrSetM = shRxPush && rxQ.size() == DEPTH && !rxPopM;
      txPopM  = shTxPop && txQ.size() > 0;
      udrSetM = shTxPop && txQ.size() == 0;
      txDrop  = txQ.size() == DEPTH && !txPopM;
      if (rxPopM) void'(rxQ.pop_front());
      if (shRxPush && !ovrSetM) rxQ.push_back(shRxData);
      if (txPopM) void'(txQ.pop_front());
      if (wrB && !txDrop) txQ.push_back(busWdata);
      if (ovrSetM) mOvr = 1; else if (rdB) mOvr = 0;
      if (udrSetM) mUdr = 1; else if (wrB) mUdr = 0;
    end
    if (busWr && busAddr == 2'd3) mEn = busWdata[0];
  endtask

  task automatic step(input logic [1:0] a, input logic rd, input logic wr,
                      input logic [7:0] wd, input logic txp, input logic rxp,
                      input logic [7:0] rxd, input string tag);
    logic [7:0] e;
    @(negedge clk);
    busAddr = a; busRd = rd; busWr = wr; busWdata = wd;
    shTxPop = txp; shRxPush = rxp; shRxData = rxd;
    #1;
    e = expRead(a);
    checks++;
    if (busRdata !== e) begin
      errors++;
      $display("FAIL %s busRdata addr=%0d actual=%h expected=%h", tag, a, busRdata, e);
    end
    if (txQ.size() > 0) begin
      checks++;
      if (shTxData !== txQ[0]) begin
        errors++;
        $display("FAIL %s shTxData actual=%h expected=%h", tag, shTxData, txQ[0]);
      end
    end
    @(posedge clk);
    modelEdge();
  endtask

  task automatic rd(input logic [1:0] a, input string tag);
    step(a, 1, 0, 8'h00, 0, 0, 8'h00, tag);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input string tag);
    step(a, 0, 1, d, 0, 0, 8'h00, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state on every address
    for (int a = 0; a < 4; a++) rd(2'(a), "R1");
    // R3: disabled unit ignores bus and shifter
    wr(2'd0, 8'h55, "R3");
    step(2'd1, 1, 0, 8'h00, 0, 1, 8'hAA, "R3");
    step(2'd2, 1, 0, 8'h00, 1, 0, 8'h00, "R3");
    // R2: enable bit, upper bits zero
    wr(2'd3, 8'hFF, "R2");
    rd(2'd3, "R2");
    rd(2'd2, "R3");
    rd(2'd1, "R3");
    // R5: transmit level encoding up to full
    for (int i = 1; i <= 4; i++) begin
      wr(2'd0, 8'(i * 17), "R5");
      rd(2'd2, "R5");
    end
    // R7: write to full transmit FIFO dropped
    wr(2'd0, 8'h99, "R7");
    rd(2'd2, "R7");
    // R6: transmit order
    for (int i = 0; i < 4; i++) step(2'd2, 1, 0, 8'h00, 1, 0, 8'h00, "R6");
    // R10: pop from empty transmit FIFO
    step(2'd2, 1, 0, 8'h00, 1, 0, 8'h00, "R10");
    rd(2'd2, "R10");
    // R11: buffer write clears underrun
    wr(2'd0, 8'h3C, "R11");
    rd(2'd2, "R11");
    step(2'd2, 1, 0, 8'h00, 1, 0, 8'h00, "R11");
    // R12: set and clear in one cycle, set wins
    step(2'd0, 0, 1, 8'h5A, 1, 0, 8'h00, "R12");
    rd(2'd2, "R12");
    // R13: transmit push and pop together
    step(2'd0, 0, 1, 8'h6B, 1, 0, 8'h00, "R13");
    rd(2'd2, "R13");
    // R5: receive level encoding
    for (int i = 0; i < 4; i++) begin
      step(2'd1, 1, 0, 8'h00, 0, 1, 8'(8'hA0 + i), "R5");
      rd(2'd1, "R5");
    end
    // R8: push into full receive FIFO
    step(2'd1, 1, 0, 8'h00, 0, 1, 8'hEE, "R8");
    rd(2'd1, "R8");
    // R9: buffer read clears overrun
    rd(2'd0, "R9");
    rd(2'd1, "R9");
    for (int i = 0; i < 3; i++) rd(2'd0, "R6");
    // R7: read of empty receive FIFO
    rd(2'd0, "R7");
    rd(2'd1, "R7");
    // R13: receive push and pop together
    step(2'd1, 1, 0, 8'h00, 0, 1, 8'h11, "R13");
    step(2'd0, 1, 0, 8'h00, 0, 1, 8'h22, "R13");
    rd(2'd1, "R13");
    // R4: disable keeps contents
    step(2'd1, 1, 0, 8'h00, 0, 1, 8'h33, "R4");
    wr(2'd3, 8'h00, "R4");
    rd(2'd1, "R4");
    rd(2'd0, "R4");
    wr(2'd3, 8'h01, "R4");
    rd(2'd1, "R4");
    rd(2'd0, "R4");
    // R6: random traffic against the model
    for (int i = 0; i < 600; i++) begin
      logic [1:0] a;
      logic r, w;
      a = 2'($urandom_range(0, 3));
      r = $urandom_range(0, 1) == 1;
      w = !r && ($urandom_range(0, 2) == 0);
      if (w && a == 2'd3 && $urandom_range(0, 3) != 0) a = 2'd0;
      step(a, r, w, 8'($urandom_range(0, 255)), $urandom_range(0, 3) == 0,
           $urandom_range(0, 2) == 0, 8'($urandom_range(0, 255)), "R6");
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule